// File: doc/BRIEF.md
# Branch Condition and Target Resolver

This block settles the fate of a single decoded branch in a 32-bit pipeline. For each strobed instruction it works out whether the branch is taken and which address comes next. It also produces the count-register value to write back. The upstream decoder supplies the instruction fields. The surrounding core supplies the current program counter, the condition register, a register holding a target address, and the count register. Three kinds of branch are handled: unconditional with a 24-bit immediate, conditional with a 14-bit displacement, and conditional to a register-held address.

For the conditional kinds, a 5-bit option field selects two gates, and the branch is taken only when both pass. The first gate may decrement the count register and test the new value for zero or nonzero. The second may compare one condition-register bit against a wanted sense. All results are registered: they appear, together with a one-cycle result strobe, on the clock edge after the input strobe.

Top module: `br_resolve`

## Requirements
- R1: After reset every output is zero. A result appears with `res_valid_o` high exactly one clock edge after `valid_i` is sampled high. `res_valid_o` and `ctr_we_o` are low in every cycle that follows a cycle without `valid_i`.
- R2: Kind 0 (unconditional) is always taken. Its offset is `li_i` followed by two zero bits, sign-extended from bit 25 of that 26-bit value, so bit 23 of `li_i` fills the upper six bits.
- R3: For kinds 1 and 2, the displacement of kind 1 is `bd_i` followed by two zero bits, sign-extended from bit 15, so bit 13 of `bd_i` fills the upper sixteen bits.
- R4: For kinds 0 and 1, `abs_i`=0 gives a target of `pc_i` plus the extended offset, and `abs_i`=1 gives a target equal to the extended value itself.
- R5: Kind 2 takes its target from `tgt_reg_i` with the two low bits cleared. `abs_i` has no effect on it.
- R6: When `bo_i[2]`=1, the count gate passes, `ctr_we_o` stays 0 and `ctr_o` equals `ctr_i`.
- R7: For kinds 1 and 2 with `bo_i[2]`=0, `ctr_o` is `ctr_i`-1 modulo 2^32 and `ctr_we_o` is 1, whether or not the branch is taken. The count gate passes when the new count is nonzero and `bo_i[1]`=0, or when it is zero and `bo_i[1]`=1. For example, 1 becomes 0 and 0 wraps to 0xFFFFFFFF.
- R8: When `bo_i[4]`=1 the condition gate passes. Otherwise it passes when bit (31 - `bi_i`) of `cr_i`, counted from the LSB, equals `bo_i[3]`.
- R9: Kinds 1 and 2 are taken only when both the count gate and the condition gate pass.
- R10: When a branch is not taken, `next_pc_o` is `pc_i` + 4.
- R11: Kind 3 is reserved. It is never taken, gives `pc_i` + 4, and never writes the count register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Branch present this cycle |
| kind_i | input | 2 | 0 unconditional, 1 conditional immediate, 2 conditional register, 3 reserved |
| li_i | input | 24 | Long immediate field |
| bd_i | input | 14 | Conditional displacement field |
| bo_i | input | 5 | Option field controlling the count and condition gates |
| bi_i | input | 5 | Condition-register bit selector |
| abs_i | input | 1 | Absolute-address select |
| pc_i | input | 32 | Address of the branch |
| tgt_reg_i | input | 32 | Register-held target address |
| cr_i | input | 32 | Condition register |
| ctr_i | input | 32 | Count register |
| res_valid_o | output | 1 | Result strobe |
| taken_o | output | 1 | Branch taken |
| next_pc_o | output | 32 | Next fetch address |
| ctr_o | output | 32 | Count register value to write |
| ctr_we_o | output | 1 | Count register write enable |

## Verification
Every result (taken flag, next address, count value and its write enable) passes through exactly one register, so it is due on the first rising edge after the strobed inputs. The bench drives each vector on a falling edge and releases the strobe on the next falling edge. It compares all four results at that moment, which is half a cycle after the capturing edge. One extra idle cycle then confirms that the result strobe and the write enable have dropped.

// File: rtl/br_pkg.sv
package br_pkg;
  localparam int BR_XLEN = 32;
  localparam int BR_LI_W = 24;
  localparam int BR_BD_W = 14;

  typedef enum logic [1:0] {
    BK_UNCOND = 2'd0,
    BK_COND   = 2'd1,
    BK_REG    = 2'd2,
    BK_RSVD   = 2'd3
  } br_kind_e;
endpackage

// File: rtl/br_target_calc.sv
module br_target_calc
  import br_pkg::*;
#(
  parameter int XLEN = BR_XLEN,
  parameter int LI_W = BR_LI_W,
  parameter int BD_W = BR_BD_W
) (
  input  br_kind_e          kind,
  input  logic [LI_W-1:0]   li,
  input  logic [BD_W-1:0]   bd,
  input  logic              abs_sel,
  input  logic [XLEN-1:0]   pc,
  input  logic [XLEN-1:0]   tgt_reg,
  output logic [XLEN-1:0]   tgt_addr,
  output logic [XLEN-1:0]   seq_pc
);
  localparam int LI_PAD = XLEN - LI_W - 2;
  localparam int BD_PAD = XLEN - BD_W - 2;
  localparam logic [XLEN-1:0] ALIGN_MASK = ~XLEN'(3);

  function automatic logic [XLEN-1:0] ext_long(input logic [LI_W-1:0] f);
    return {{LI_PAD{f[LI_W-1]}}, f, 2'b00};
  endfunction

  function automatic logic [XLEN-1:0] ext_short(input logic [BD_W-1:0] f);
    return {{BD_PAD{f[BD_W-1]}}, f, 2'b00};
  endfunction

  function automatic logic [XLEN-1:0] place(input logic a,
                                             input logic [XLEN-1:0] base,
                                             input logic [XLEN-1:0] off);
    return a ? off : base + off;
  endfunction

  logic [XLEN-1:0] off_long, off_short;
  assign off_long  = ext_long(li);
  assign off_short = ext_short(bd);
  assign seq_pc    = pc + XLEN'(4);

  always_comb begin
    unique case (kind)
      BK_UNCOND: tgt_addr = place(abs_sel, pc, off_long);
      BK_COND:   tgt_addr = place(abs_sel, pc, off_short);
      BK_REG:    tgt_addr = tgt_reg & ALIGN_MASK;
      default:   tgt_addr = seq_pc;
    endcase
  end
endmodule

// File: rtl/br_cond_eval.sv
module br_cond_eval
  import br_pkg::*;
#(
  parameter int XLEN = BR_XLEN
) (
  input  br_kind_e         kind,
  input  logic [4:0]       bo,
  input  logic [4:0]       bi,
  input  logic [XLEN-1:0]  cr,
  input  logic [XLEN-1:0]  ctr,
  output logic             is_cond,
  output logic             cnt_ok,
  output logic             cond_ok,
  output logic             ctr_wr,
  output logic [XLEN-1:0]  ctr_new
);
  function automatic logic cr_pick(input logic [XLEN-1:0] r, input logic [4:0] sel);
    return r[(XLEN-1) - int'(sel)];
  endfunction

  function automatic logic count_gate(input logic skip, input logic want_zero,
                                      input logic [XLEN-1:0] nv);
    if (skip) return 1'b1;
    return want_zero ? (nv == '0) : (nv != '0);
  endfunction

  logic no_dec, want_zero, no_cr, cr_sense;
  assign no_dec    = bo[2];
  assign want_zero = bo[1];
  assign no_cr     = bo[4];
  assign cr_sense  = bo[3];

  assign is_cond = (kind == BK_COND) || (kind == BK_REG);
  assign ctr_wr  = is_cond && !no_dec;
  assign ctr_new = ctr_wr ? ctr - XLEN'(1) : ctr;
  assign cnt_ok  = count_gate(no_dec, want_zero, ctr_new);
  assign cond_ok = no_cr || (cr_pick(cr, bi) == cr_sense);
endmodule

// File: rtl/br_result_reg.sv
module br_result_reg
  import br_pkg::*;
#(
  parameter int XLEN = BR_XLEN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             taken_d,
  input  logic [XLEN-1:0]  npc_d,
  input  logic [XLEN-1:0]  ctr_d,
  input  logic             ctr_we_d,
  output logic             vld_q,
  output logic             taken_q,
  output logic [XLEN-1:0]  npc_q,
  output logic [XLEN-1:0]  ctr_q,
  output logic             ctr_we_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q    <= 1'b0;
      taken_q  <= 1'b0;
      npc_q    <= '0;
      ctr_q    <= '0;
      ctr_we_q <= 1'b0;
    end else begin
      vld_q    <= load;
      ctr_we_q <= load && ctr_we_d;
      if (load) begin
        taken_q <= taken_d;
        npc_q   <= npc_d;
        ctr_q   <= ctr_d;
      end
    end
  end
endmodule

// File: rtl/br_resolve.sv
module br_resolve
  import br_pkg::*;
#(
  parameter int XLEN = BR_XLEN,
  parameter int LI_W = BR_LI_W,
  parameter int BD_W = BR_BD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic [1:0]       kind_i,
  input  logic [LI_W-1:0]  li_i,
  input  logic [BD_W-1:0]  bd_i,
  input  logic [4:0]       bo_i,
  input  logic [4:0]       bi_i,
  input  logic             abs_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic [XLEN-1:0]  tgt_reg_i,
  input  logic [XLEN-1:0]  cr_i,
  input  logic [XLEN-1:0]  ctr_i,
  output logic             res_valid_o,
  output logic             taken_o,
  output logic [XLEN-1:0]  next_pc_o,
  output logic [XLEN-1:0]  ctr_o,
  output logic             ctr_we_o
);
  br_kind_e        kind;
  logic [XLEN-1:0] tgt_addr, seq_pc, ctr_new, npc_d;
  logic            is_cond, cnt_ok, cond_ok, ctr_wr, taken_d;

  assign kind = br_kind_e'(kind_i);

  br_target_calc #(.XLEN(XLEN), .LI_W(LI_W), .BD_W(BD_W)) u_tgt (
    .kind(kind), .li(li_i), .bd(bd_i), .abs_sel(abs_i), .pc(pc_i),
    .tgt_reg(tgt_reg_i), .tgt_addr(tgt_addr), .seq_pc(seq_pc)
  );

  br_cond_eval #(.XLEN(XLEN)) u_cond (
    .kind(kind), .bo(bo_i), .bi(bi_i), .cr(cr_i), .ctr(ctr_i),
    .is_cond(is_cond), .cnt_ok(cnt_ok), .cond_ok(cond_ok),
    .ctr_wr(ctr_wr), .ctr_new(ctr_new)
  );

  assign taken_d = (kind == BK_UNCOND) || (is_cond && cnt_ok && cond_ok);
  assign npc_d   = taken_d ? tgt_addr : seq_pc;

  br_result_reg #(.XLEN(XLEN)) u_out (
    .clk(clk), .rst_n(rst_n), .load(valid_i),
    .taken_d(taken_d), .npc_d(npc_d), .ctr_d(ctr_new), .ctr_we_d(ctr_wr),
    .vld_q(res_valid_o), .taken_q(taken_o), .npc_q(next_pc_o),
    .ctr_q(ctr_o), .ctr_we_q(ctr_we_o)
  );
endmodule

// File: rtl/br_resolve_chk.sv
module br_resolve_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            valid_i,
  input logic [1:0]      kind_i,
  input logic            bo_nodec,
  input logic [XLEN-1:0] pc_i,
  input logic [XLEN-1:0] ctr_i,
  input logic            res_valid_o,
  input logic            taken_o,
  input logic [XLEN-1:0] next_pc_o,
  input logic [XLEN-1:0] ctr_o,
  input logic            ctr_we_o
);
  a_r1_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> res_valid_o);
  a_r1_strobe_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> (!res_valid_o && !ctr_we_o));
  a_r2_uncond_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && kind_i == 2'd0) |=> taken_o);
  a_r5_reg_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && kind_i == 2'd2) |=> (!taken_o || next_pc_o[1:0] == 2'b00));
  a_r6_no_count_write: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && bo_nodec) |=> (!ctr_we_o && ctr_o == $past(ctr_i)));
  a_r7_count_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && (kind_i == 2'd1 || kind_i == 2'd2) && !bo_nodec)
      |=> (ctr_we_o && ctr_o == $past(ctr_i) - XLEN'(1)));
  a_r10_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && !taken_o) |-> next_pc_o == $past(pc_i) + XLEN'(4));
  a_r11_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && kind_i == 2'd3) |=> (!taken_o && !ctr_we_o));
endmodule

bind br_resolve br_resolve_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .kind_i(kind_i),
  .bo_nodec(bo_i[2]), .pc_i(pc_i), .ctr_i(ctr_i),
  .res_valid_o(res_valid_o), .taken_o(taken_o), .next_pc_o(next_pc_o),
  .ctr_o(ctr_o), .ctr_we_o(ctr_we_o)
);

// File: tb/sim_br_resolve.sv
module sim_br_resolve;
  localparam int CLK_PER = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  kind_i = '0;
  logic [23:0] li_i = '0;
  logic [13:0] bd_i = '0;
  logic [4:0]  bo_i = '0, bi_i = '0;
  logic        abs_i = 1'b0;
  logic [31:0] pc_i = '0, tgt_reg_i = '0, cr_i = '0, ctr_i = '0;
  logic        res_valid_o, taken_o, ctr_we_o;
  logic [31:0] next_pc_o, ctr_o;

  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_PER/2) clk = ~clk;

  br_resolve u0 (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .kind_i(kind_i),
    .li_i(li_i), .bd_i(bd_i), .bo_i(bo_i), .bi_i(bi_i), .abs_i(abs_i),
    .pc_i(pc_i), .tgt_reg_i(tgt_reg_i), .cr_i(cr_i), .ctr_i(ctr_i),
    .res_valid_o(res_valid_o), .taken_o(taken_o), .next_pc_o(next_pc_o),
    .ctr_o(ctr_o), .ctr_we_o(ctr_we_o)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic apply(input string req, input logic [1:0] k, input logic [23:0] li,
                       input logic [13:0] bd, input logic [4:0] bo, input logic [4:0] bi,
                       input logic ab, input logic [31:0] pc, input logic [31:0] tr,
                       input logic [31:0] cr, input logic [31:0] ctr);
    logic [31:0] off, tgt, e_ctr, e_pc;
    logic        dec, c_pass, r_pass, e_tk;
    dec = (k == 2'd1 || k == 2'd2) && (bo[2] == 1'b0);
    e_ctr = dec ? ctr + 32'hFFFF_FFFF : ctr;
    if (bo[2]) c_pass = 1'b1;
    else if (bo[1]) c_pass = (e_ctr == 32'd0);
    else c_pass = (e_ctr != 32'd0);
    r_pass = bo[4] | (((cr << bi) >> 31) == {31'd0, bo[3]});
    case (k)
      2'd0: begin off = 32'($signed({li, 2'b00})); tgt = ab ? off : pc + off; e_tk = 1'b1; end
      2'd1: begin off = 32'($signed({bd, 2'b00})); tgt = ab ? off : pc + off; e_tk = c_pass & r_pass; end
      2'd2: begin tgt = {tr[31:2], 2'b00}; e_tk = c_pass & r_pass; end
      default: begin tgt = 32'd0; e_tk = 1'b0; end
    endcase
    e_pc = e_tk ? tgt : pc + 32'd4;
    @(negedge clk);
    kind_i = k; li_i = li; bd_i = bd; bo_i = bo; bi_i = bi; abs_i = ab;
    pc_i = pc; tgt_reg_i = tr; cr_i = cr; ctr_i = ctr; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    check("R1", "res_valid", {31'd0, res_valid_o}, 32'd1);
    check(req, "taken", {31'd0, taken_o}, {31'd0, e_tk});
    check(req, "next_pc", next_pc_o, e_pc);
    check(req, "ctr", ctr_o, e_ctr);
    check(req, "ctr_we", {31'd0, ctr_we_o}, {31'd0, dec});
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1", "reset valid", {31'd0, res_valid_o}, 32'd0);
    check("R1", "reset taken", {31'd0, taken_o}, 32'd0);
    check("R1", "reset pc", next_pc_o, 32'd0);
    check("R1", "reset ctr", ctr_o, 32'd0);
    check("R1", "reset we", {31'd0, ctr_we_o}, 32'd0);
    rst_n = 1'b1;
  endtask

  task automatic t_idle();
    @(negedge clk);
    check("R1", "idle valid", {31'd0, res_valid_o}, 32'd0);
    check("R1", "idle we", {31'd0, ctr_we_o}, 32'd0);
  endtask

  task automatic t_uncond();
    apply("R2", 2'd0, 24'h000010, 14'h0, 5'b0, 5'd0, 1'b0, 32'h1000, 32'h0, 32'h0, 32'h5);
    apply("R2", 2'd0, 24'h800000, 14'h0, 5'b0, 5'd0, 1'b0, 32'h1000, 32'h0, 32'h0, 32'h5);
    apply("R4", 2'd0, 24'h3FFFFF, 14'h0, 5'b0, 5'd0, 1'b1, 32'h1000, 32'h0, 32'h0, 32'h0);
    apply("R4", 2'd0, 24'hFFFFFF, 14'h0, 5'b0, 5'd0, 1'b1, 32'h1000, 32'h0, 32'h0, 32'h0);
    t_idle();
  endtask

  task automatic t_cond_imm();
    apply("R3", 2'd1, 24'h0, 14'h2000, 5'b10100, 5'd0, 1'b0, 32'h2000, 32'h0, 32'h0, 32'h9);
    apply("R3", 2'd1, 24'h0, 14'h0004, 5'b10100, 5'd0, 1'b0, 32'h2000, 32'h0, 32'h0, 32'h9);
    apply("R4", 2'd1, 24'h0, 14'h3FFF, 5'b10100, 5'd0, 1'b1, 32'h2000, 32'h0, 32'h0, 32'h9);
  endtask

  task automatic t_reg();
    apply("R5", 2'd2, 24'h0, 14'h0, 5'b10100, 5'd0, 1'b0, 32'h40, 32'h12345677, 32'h0, 32'h1);
    apply("R5", 2'd2, 24'h0, 14'h1234, 5'b10100, 5'd0, 1'b1, 32'h40, 32'hABCDEF02, 32'h0, 32'h1);
  endtask

  task automatic t_count();
    apply("R7", 2'd1, 24'h0, 14'h10, 5'b10000, 5'd0, 1'b0, 32'h100, 32'h0, 32'h0, 32'd1);
    apply("R7", 2'd1, 24'h0, 14'h10, 5'b10000, 5'd0, 1'b0, 32'h100, 32'h0, 32'h0, 32'd0);
    apply("R7", 2'd2, 24'h0, 14'h0, 5'b10010, 5'd0, 1'b0, 32'h100, 32'h800, 32'h0, 32'd1);
    apply("R7", 2'd2, 24'h0, 14'h0, 5'b10010, 5'd0, 1'b0, 32'h100, 32'h800, 32'h0, 32'd7);
    apply("R6", 2'd1, 24'h0, 14'h10, 5'b10110, 5'd0, 1'b0, 32'h100, 32'h0, 32'h0, 32'd0);
    t_idle();
  endtask

  task automatic t_crbit();
    apply("R8", 2'd1, 24'h0, 14'h8, 5'b01100, 5'd0, 1'b0, 32'h300, 32'h0, 32'h8000_0000, 32'd3);
    apply("R8", 2'd1, 24'h0, 14'h8, 5'b01100, 5'd0, 1'b0, 32'h300, 32'h0, 32'h7FFF_FFFF, 32'd3);
    apply("R8", 2'd1, 24'h0, 14'h8, 5'b01100, 5'd31, 1'b0, 32'h300, 32'h0, 32'h1, 32'd3);
    apply("R8", 2'd1, 24'h0, 14'h8, 5'b00100, 5'd31, 1'b0, 32'h300, 32'h0, 32'h1, 32'd3);
    apply("R9", 2'd1, 24'h0, 14'h8, 5'b01000, 5'd2, 1'b0, 32'h300, 32'h0, 32'h2000_0000, 32'd5);
    apply("R9", 2'd1, 24'h0, 14'h8, 5'b01000, 5'd2, 1'b0, 32'h300, 32'h0, 32'h2000_0000, 32'd1);
    apply("R10", 2'd1, 24'h0, 14'h8, 5'b01000, 5'd2, 1'b0, 32'h300, 32'h0, 32'h0, 32'd5);
  endtask

  task automatic t_reserved();
    apply("R11", 2'd3, 24'h000100, 14'h100, 5'b00000, 5'd0, 1'b0, 32'h700, 32'h900, 32'h0, 32'd4);
  endtask

  task automatic t_random();
    for (int i = 0; i < 400; i++) begin
      apply("R9", 2'($urandom_range(0, 2)), 24'($urandom), 14'($urandom),
            5'($urandom), 5'($urandom), 1'($urandom), $urandom, $urandom,
            $urandom, ($urandom_range(0, 3) == 0) ? 32'($urandom_range(0, 2)) : $urandom);
    end
  endtask

  initial begin
    t_reset();
    t_uncond();
    t_cond_imm();
    t_reg();
    t_count();
    t_crbit();
    t_reserved();
    t_random();
    t_idle();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PER * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule